// File: doc/BRIEF.md
# Multi-Waveform Phase-Accumulator Function Generator

This block produces an 8-bit digital sample stream for a simple function generator. A wide phase register grows by a tuning word on every rising clock edge. The top eight phase bits either address a sine table that holds one period, or directly form a square, triangle or ramp shape. A 2-bit select input chooses the shape, and a 4-bit gain code scales the chosen sample. Amplitude can therefore change without reloading any waveform data. The scaled sample is registered and goes to an external DAC once per clock.

The output frequency is set by a rotary encoder. Its two quadrature lines are synchronised and debounced. Each detent in one direction raises the tuning word by a fixed step, and each detent in the other direction lowers it by the same step. The tuning word is held inside a window that matches the lowest and highest wanted frequency. With the default parameters and a 100 MHz clock, that window spans 0.1 Hz to 100 kHz.

Top module: `dds_fgen`

## Requirements
- R1: While `rst` is high on a clock edge, the phase is cleared to zero, the tuning word loads `TW_INIT`, the encoder filters clear to 0 and `sample` becomes 0.
- R2: On every clock edge out of reset, the phase grows by the tuning word modulo 2^PHASE_W. `sample` takes a new value on each edge, computed from the phase held before that edge.
- R3: `wave_sel` encoding is 0 sine, 1 square, 2 triangle, 3 ramp. `wave_sel` and `gain` are sampled on the same edge as the phase they are applied to.
- R4: In sine mode, with top phase byte k, the unscaled sample is floor(128 + 127·sin(2πk/256) + 0.5), allowing for one code of rounding difference.
- R5: In square mode, the unscaled sample is 255 when the phase MSB is 1 and 0 otherwise.
- R6: In triangle mode, with top phase byte k, the unscaled sample is 2k for k < 128 and 2·(255 − k) for k ≥ 128.
- R7: In ramp mode, the unscaled sample is the top phase byte k.
- R8: The output is min(255, floor(s·g/8)), where s is the unscaled sample and g is the 4-bit gain. g = 8 is unity and g = 0 mutes the output.
- R9: Each encoder line passes through a two-flop synchroniser. A change is accepted only when the synchronised level has differed from the filtered level on `DEBOUNCE` consecutive edges. Shorter pulses have no effect on the tuning word.
- R10: A rising edge of filtered A while filtered B is 0 adds `TW_STEP`. A rising edge while B is 1 subtracts `TW_STEP`. The new tuning word takes effect one edge after filtered A rises, and first shows in `sample` two edges later. A falling edge of A does nothing.
- R11: The tuning word never leaves [`TW_MIN`, `TW_MAX`]. A step that would cross a bound lands on that bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder quadrature line A (asynchronous) |
| enc_b | input | 1 | Encoder quadrature line B (asynchronous) |
| wave_sel | input | 2 | Shape select: 0 sine, 1 square, 2 triangle, 3 ramp |
| gain | input | 4 | Amplitude code, 8 = unity |
| sample | output | 8 | Registered unsigned sample to the DAC |

## Verification
The bench builds the block with a 16-bit phase, a tuning window of 256 to 1024, a step of 256, a start value of 512 and a debounce length of 3. With these values the top phase byte moves one to four codes per clock. A few hundred cycles therefore sweep the whole sine table and every triangle and ramp code, and three detents reach either clamp bound. The short debounce allows pulses of one, two and exactly three cycles, so both sides of the acceptance threshold are tested. A free-running reference model follows the encoder and tuning word and compares every output sample.

// File: rtl/fgen_pkg.sv
`timescale 1ns/1ps
package fgen_pkg;

    localparam int SAMPLE_W = 8;
    localparam int INDEX_W  = 8;
    localparam int GAIN_W   = 4;
    localparam int GAIN_SH  = 3;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_TRI    = 2'd2,
        WAVE_RAMP   = 2'd3
    } wave_e;

    typedef struct packed {
        logic up;
        logic down;
    } detent_t;

    // Sine code for table index k, from a fixed-point series on a quarter wave.
    function automatic logic [SAMPLE_W-1:0] sine_code(input int unsigned k);
        longint      x;
        longint      term;
        longint      acc;
        longint      num;
        int unsigned r;
        int unsigned quad;
        quad = (k >> 6) & 32'd3;
        r    = k & 32'd63;
        if (quad[0]) r = 32'd64 - r;
        x    = (64'sd843314857 * longint'(r)) / 64'sd128;
        term = x;
        acc  = x;
        for (int n = 1; n <= 6; n++) begin
            term = -((((term * x) >>> 28) * x) >>> 28) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        if (quad[1]) acc = -acc;
        num = 64'sd127 * acc + (64'sd128 <<< 28) + (64'sd1 <<< 27);
        return SAMPLE_W'(num >>> 28);
    endfunction

    // Multiply by gain code, divide by 8, saturate.
    function automatic logic [SAMPLE_W-1:0] apply_gain(input logic [SAMPLE_W-1:0] s,
                                                       input logic [GAIN_W-1:0]   g);
        logic [SAMPLE_W+GAIN_W-1:0] prod;
        logic [SAMPLE_W+GAIN_W-GAIN_SH-1:0] scaled;
        prod   = {{GAIN_W{1'b0}}, s} * {{SAMPLE_W{1'b0}}, g};
        scaled = (SAMPLE_W+GAIN_W-GAIN_SH)'(prod >> GAIN_SH);
        return (scaled > {{(GAIN_W-GAIN_SH){1'b0}}, {SAMPLE_W{1'b1}}}) ? {SAMPLE_W{1'b1}}
                                                                       : scaled[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/fgen_quad_in.sv
`timescale 1ns/1ps
module fgen_quad_in
    import fgen_pkg::*;
#(
    parameter int DEBOUNCE = 100000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    line_a,
    input  logic    line_b,
    output detent_t det
);
    localparam int CNT_W = $clog2(DEBOUNCE + 1);
    localparam int LINES = 2;

    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] clean_q;
    logic [LINES-1:0] clean_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= '0;
            sync_q    <= '0;
            clean_d_q <= '0;
        end else begin
            meta_q    <= {line_b, line_a};
            sync_q    <= meta_q;
            clean_d_q <= clean_q;
        end
    end

    for (genvar ch = 0; ch < LINES; ch++) begin : g_line
        logic [CNT_W-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                run_q       <= '0;
                clean_q[ch] <= 1'b0;
            end else if (sync_q[ch] == clean_q[ch]) begin
                run_q <= '0;
            end else if (run_q == CNT_W'(DEBOUNCE - 1)) begin
                run_q       <= '0;
                clean_q[ch] <= sync_q[ch];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end

        // R9: a filtered level only ever adopts the synchronised level
        p_filter_from_sync_r9: assert property (@(posedge clk) disable iff (rst)
            (clean_q[ch] != $past(clean_q[ch])) |-> (clean_q[ch] == $past(sync_q[ch])));
    end

    always_comb begin
        det.up   = clean_q[0] & ~clean_d_q[0] & ~clean_q[1];
        det.down = clean_q[0] & ~clean_d_q[0] &  clean_q[1];
    end

endmodule

// File: rtl/fgen_tuning.sv
`timescale 1ns/1ps
module fgen_tuning
    import fgen_pkg::*;
#(
    parameter int              TW_W    = 49,
    parameter longint unsigned TW_MIN  = 64'd562950,
    parameter longint unsigned TW_MAX  = 64'd562949953421,
    parameter longint unsigned TW_STEP = 64'd56294995,
    parameter longint unsigned TW_INIT = 64'd5629499534
) (
    input  logic            clk,
    input  logic            rst,
    input  detent_t         det,
    output logic [TW_W-1:0] tw
);
    localparam logic [TW_W:0] MIN_X  = TW_MIN[TW_W:0];
    localparam logic [TW_W:0] MAX_X  = TW_MAX[TW_W:0];
    localparam logic [TW_W:0] STEP_X = TW_STEP[TW_W:0];
    localparam logic [TW_W:0] INIT_X = TW_INIT[TW_W:0];

    logic [TW_W-1:0] tw_q;
    logic [TW_W:0]   up_sum;
    logic [TW_W-1:0] dn_diff;
    logic            up_over;
    logic            dn_under;

    always_comb begin
        up_sum   = {1'b0, tw_q} + STEP_X;
        dn_diff  = tw_q - STEP_X[TW_W-1:0];
        up_over  = up_sum > MAX_X;
        dn_under = {1'b0, tw_q} < (MIN_X + STEP_X);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tw_q <= INIT_X[TW_W-1:0];
        end else if (det.up) begin
            tw_q <= up_over ? MAX_X[TW_W-1:0] : up_sum[TW_W-1:0];
        end else if (det.down) begin
            tw_q <= dn_under ? MIN_X[TW_W-1:0] : dn_diff;
        end
    end

    assign tw = tw_q;

    p_tw_window_r11: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, tw_q} >= MIN_X) && ({1'b0, tw_q} <= MAX_X));

    p_tw_moves_on_detent_r10: assert property (@(posedge clk) disable iff (rst)
        (tw_q != $past(tw_q)) |-> $past(det.up || det.down));

endmodule

// File: rtl/fgen_phase.sv
`timescale 1ns/1ps
module fgen_phase
    import fgen_pkg::*;
#(
    parameter int PHASE_W = 49
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tw,
    output logic [INDEX_W-1:0] phase_top
);
    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + tw;
    end

    assign phase_top = phase_q[PHASE_W-1 -: INDEX_W];

    p_phase_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase_q == '0));

endmodule

// File: rtl/fgen_shaper.sv
`timescale 1ns/1ps
module fgen_shaper
    import fgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INDEX_W-1:0]  idx,
    input  wave_e               sel,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [SAMPLE_W-1:0] sine_rom [DEPTH];
    logic [SAMPLE_W-1:0] shaped;
    logic [SAMPLE_W-1:0] sample_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        localparam logic [SAMPLE_W-1:0] CODE = sine_code(i);
        assign sine_rom[i] = CODE;
    end

    always_comb begin
        shaped = idx;
        unique case (sel)
            WAVE_SINE:   shaped = sine_rom[idx];
            WAVE_SQUARE: shaped = {SAMPLE_W{idx[INDEX_W-1]}};
            WAVE_TRI:    shaped = {idx[INDEX_W-1] ? ~idx[INDEX_W-2:0] : idx[INDEX_W-2:0], 1'b0};
            WAVE_RAMP:   shaped = idx;
            default:     shaped = idx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= apply_gain(shaped, gain);
    end

    assign sample = sample_q;

    p_mute_r8: assert property (@(posedge clk) disable iff (rst)
        $past(gain == '0) |-> (sample_q == '0));

    p_square_rails_r5: assert property (@(posedge clk) disable iff (rst)
        $past(sel == WAVE_SQUARE && gain == GAIN_W'(8)) |-> (sample_q == '0 || sample_q == '1));

endmodule

// File: rtl/dds_fgen.sv
`timescale 1ns/1ps
module dds_fgen
    import fgen_pkg::*;
#(
    parameter int              PHASE_W  = 49,
    parameter longint unsigned TW_MIN   = 64'd562950,
    parameter longint unsigned TW_MAX   = 64'd562949953421,
    parameter longint unsigned TW_STEP  = 64'd56294995,
    parameter longint unsigned TW_INIT  = 64'd5629499534,
    parameter int              DEBOUNCE = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic [1:0] wave_sel,
    input  logic [3:0] gain,
    output logic [7:0] sample
);
    detent_t             det;
    logic [PHASE_W-1:0]  tw;
    logic [INDEX_W-1:0]  phase_top;
    wave_e               sel_e;

    assign sel_e = wave_e'(wave_sel);

    fgen_quad_in #(.DEBOUNCE(DEBOUNCE)) u_quad (
        .clk    (clk),
        .rst    (rst),
        .line_a (enc_a),
        .line_b (enc_b),
        .det    (det)
    );

    fgen_tuning #(
        .TW_W    (PHASE_W),
        .TW_MIN  (TW_MIN),
        .TW_MAX  (TW_MAX),
        .TW_STEP (TW_STEP),
        .TW_INIT (TW_INIT)
    ) u_tuning (
        .clk (clk),
        .rst (rst),
        .det (det),
        .tw  (tw)
    );

    fgen_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .tw        (tw),
        .phase_top (phase_top)
    );

    fgen_shaper u_shaper (
        .clk    (clk),
        .rst    (rst),
        .idx    (phase_top),
        .sel    (sel_e),
        .gain   (gain),
        .sample (sample)
    );

endmodule

// File: tb/dds_fgen_test.sv
`timescale 1ns/1ps
module dds_fgen_test;

    localparam int              PW    = 16;
    localparam longint unsigned TMIN  = 64'd256;
    localparam longint unsigned TMAX  = 64'd1024;
    localparam longint unsigned TSTEP = 64'd256;
    localparam longint unsigned TINIT = 64'd512;
    localparam int              DEB   = 3;
    localparam longint unsigned PMASK = (64'd1 << PW) - 64'd1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic [1:0] wave_sel = 2'd3;
    logic [3:0] gain = 4'd8;
    logic [7:0] sample;

    int vectors = 0;
    int fails   = 0;
    string req  = "R1";

    longint unsigned m_phase = 0;
    longint unsigned m_tw    = TINIT;
    int m_out = 0;
    int pend  = 0;
    int sy1 [2];
    int sy2 [2];
    int filt [2];
    int run [2];

    always #5 clk = ~clk;

    dds_fgen #(
        .PHASE_W  (PW),
        .TW_MIN   (TMIN),
        .TW_MAX   (TMAX),
        .TW_STEP  (TSTEP),
        .TW_INIT  (TINIT),
        .DEBOUNCE (DEB)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .wave_sel (wave_sel),
        .gain     (gain),
        .sample   (sample)
    );

    function automatic string shape_req(input int s);
        case (s)
            0:       return "R4";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference shapes and gain (R4..R8)
    function automatic int expect_sample(input int s, input int g, input longint unsigned ph);
        int k;
        int v;
        k = int'((ph >> (PW - 8)) & 64'd255);
        case (s)
            0:       v = $rtoi($floor(128.0 + 127.0 * $sin(6.283185307179586 * k / 256.0) + 0.5));
            1:       v = (k >= 128) ? 255 : 0;
            2:       v = (k < 128) ? 2 * k : 2 * (255 - k);
            default: v = k;
        endcase
        v = (v * g) / 8;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic model_edge();
        int ins [2];
        int rose_a;
        ins[0] = int'(enc_a);
        ins[1] = int'(enc_b);
        if (rst) begin
            m_phase = 0;
            m_tw    = TINIT;
            m_out   = 0;
            pend    = 0;
            for (int ch = 0; ch < 2; ch++) begin
                sy1[ch] = 0; sy2[ch] = 0; filt[ch] = 0; run[ch] = 0;
            end
        end else begin
            m_out   = expect_sample(int'(wave_sel), int'(gain), m_phase);
            m_phase = (m_phase + m_tw) & PMASK;
            if (pend == 1)
                m_tw = (m_tw + TSTEP > TMAX) ? TMAX : m_tw + TSTEP;
            else if (pend == -1)
                m_tw = (m_tw < TMIN + TSTEP) ? TMIN : m_tw - TSTEP;
            pend   = 0;
            rose_a = 0;
            for (int ch = 0; ch < 2; ch++) begin
                if (sy2[ch] == filt[ch]) begin
                    run[ch] = 0;
                end else begin
                    run[ch]++;
                    if (run[ch] == DEB) begin
                        if (ch == 0 && sy2[0] == 1) rose_a = 1;
                        filt[ch] = sy2[ch];
                        run[ch]  = 0;
                    end
                end
            end
            if (rose_a != 0) pend = (filt[1] != 0) ? -1 : 1;
            for (int ch = 0; ch < 2; ch++) begin
                sy2[ch] = sy1[ch];
                sy1[ch] = ins[ch];
            end
        end
    endtask

    task automatic compare();
        int d;
        int tol;
        vectors++;
        d = int'(sample) - m_out;
        if (d < 0) d = -d;
        tol = (wave_sel == 2'd0 && !rst) ? (int'(gain) / 8) + 1 : 0;
        if (d > tol) begin
            fails++;
            $display("FAIL %s/%s: sample=%0d expected=%0d (sel=%0d gain=%0d)",
                     req, shape_req(int'(wave_sel)), sample, m_out, wave_sel, gain);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_edge();
        compare();
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic detent_cw();
        enc_b = 1'b0; enc_a = 1'b1; run_n(8);
        enc_b = 1'b1; run_n(8);
        enc_a = 1'b0; run_n(8);
        enc_b = 1'b0; run_n(8);
    endtask

    task automatic detent_ccw();
        enc_b = 1'b1; run_n(8);
        enc_a = 1'b1; run_n(8);
        enc_b = 1'b0; run_n(8);
        enc_a = 1'b0; run_n(8);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        req = "R1";
        run_n(4);
        rst = 1'b0;

        // R2, R3, R7: ramp at unity gain
        req = "R2"; wave_sel = 2'd3; gain = 4'd8; run_n(300);
        req = "R3"; wave_sel = 2'd0; run_n(300);     // R4 sine
        wave_sel = 2'd1; run_n(200);                  // R5 square
        wave_sel = 2'd2; run_n(300);                  // R6 triangle
        wave_sel = 2'd3; run_n(100);                  // R7 ramp

        // R8: gain codes, mute, attenuate, saturate
        req = "R8";
        gain = 4'd0;  run_n(100);
        gain = 4'd4;  run_n(100);
        gain = 4'd15; run_n(150);
        wave_sel = 2'd0; gain = 4'd12; run_n(150);
        wave_sel = 2'd2; gain = 4'd3;  run_n(100);
        wave_sel = 2'd3; gain = 4'd8;

        // R10: one detent each way
        req = "R10";
        detent_cw();  run_n(40);
        detent_ccw(); run_n(40);

        // R11: drive into both clamp bounds
        req = "R11";
        for (int i = 0; i < 4; i++) detent_cw();
        run_n(60);
        for (int i = 0; i < 5; i++) detent_ccw();
        run_n(60);
        detent_cw(); run_n(40);

        // R9: pulses of 1 and 2 cycles are rejected, exactly 3 is accepted
        req = "R9";
        enc_a = 1'b1; run_n(1); enc_a = 1'b0; run_n(20);
        enc_a = 1'b1; run_n(2); enc_a = 1'b0; run_n(20);
        enc_b = 1'b1; run_n(2); enc_b = 1'b0; run_n(20);
        enc_a = 1'b1; run_n(3); enc_a = 1'b0; run_n(40);

        // R1: reset in mid-run restores phase and tuning word
        req = "R1";
        wave_sel = 2'd1;
        rst = 1'b1; run_n(2);
        rst = 1'b0; wave_sel = 2'd3; run_n(120);

        summary();
        $finish;
    end

endmodule